// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port with Bus-Conflict Detection

This block is a synchronous serial port that can run as the bus master or as a selected slave. A configuration input picks the role. As master it generates a serial clock from the system clock through a programmable divider. The clock toggles only while a word is moving, and each bit takes one full clock cycle. As slave it follows an external serial clock, but only while its active-low select input is low. Clock idle level, clock phase, word length (8, 16 or the full data width) and bit order can all be set. The slave data output can be switched to open-drain signalling.

Every pin has a separate input, output and output enable, so the block can turn its pins around when the role changes. In master mode the select input must stay high. If that input goes low, another device is trying to drive the bus. The block then records a conflict, stops its transfer and falls back to the slave role until software clears the flag. A word is handed over with a single-cycle load strobe. A received word comes back with a single-cycle valid strobe. A load strobe that arrives while a word is in flight is refused and recorded as an overflow.

Top module: `spi_port`

## Requirements
- R1: As master, one load produces exactly 2×N serial clock edges for an N-bit word. The serial clock rests at the level of `cfg_cpol` before and after the word.
- R2: As master, consecutive serial clock edges are `cfg_div`+1 system clock cycles apart.
- R3: `cfg_len` selects the word length: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives `DATA_W` bits. With `cfg_lsb_first`=1, bit 0 of the word goes first. With `cfg_lsb_first`=0, bit N-1 goes first. The transmitted bits are the low N bits of `tx_data`.
- R4: With `cfg_cpha`=0, the first bit is valid before the first edge, bits are captured on leading edges and changed on trailing edges. With `cfg_cpha`=1, bits are changed on leading edges and captured on trailing edges.
- R5: As master, the bits captured from `miso_i` are assembled into `rx_data` in the selected order and length, right-aligned. `rx_valid` pulses for one cycle when the word is complete.
- R6: In the master role, `sclk_oe` and `mosi_oe` are 1 and `miso_oe` is 0. In the slave role, `sclk_oe` and `mosi_oe` are 0.
- R7: As slave, the block ignores `sclk_i` while `ss_n_i` is high. Raising `ss_n_i` mid-word drops the partial word, and `busy` returns to 0. While `ss_n_i` is low, the bits on `mosi_i` are assembled into `rx_data`, and `rx_valid` pulses once per word.
- R8: As slave, `miso_oe` is 0 whenever `ss_n_i` is high. While selected, the block sends the loaded word on MISO under the same order, length and phase rules.
- R9: With `cfg_miso_od`=1, the slave enables MISO only for 0 bits and drives it low. For 1 bits it releases the pin.
- R10: A low on the select input while `cfg_master`=1 sets `mm_err`. The block then aborts the word and produces no `rx_valid` for it. It also disables `sclk_oe` and `mosi_oe` until `status_clr` is pulsed with the select input high.
- R11: A `tx_load` while `busy`=1 sets `ovf_flag`, and the word in flight goes out and comes back unchanged. `status_clr` clears `ovf_flag`.
- R12: After reset, `busy`, `rx_valid`, `ovf_flag`, `mm_err` and `rx_data` are 0, and with `cfg_master`=0 all three output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects the master role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| cfg_len | input | 2 | Word length code |
| cfg_miso_od | input | 1 | Open-drain MISO enable |
| cfg_div | input | DIV_W | Baud divider; half period is cfg_div+1 cycles |
| tx_data | input | DATA_W | Word to send |
| tx_load | input | 1 | Single-cycle load strobe |
| rx_data | output | DATA_W | Last received word, right-aligned |
| rx_valid | output | 1 | Single-cycle receive strobe |
| busy | output | 1 | Word in flight |
| ovf_flag | output | 1 | Sticky load-while-busy flag |
| mm_err | output | 1 | Sticky bus-conflict flag |
| status_clr | input | 1 | Clears ovf_flag and mm_err |
| sclk_i | input | 1 | Serial clock pin input |
| sclk_o | output | 1 | Serial clock pin output |
| sclk_oe | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Active-low select input |
| mosi_i | input | 1 | MOSI pin input (slave data in) |
| mosi_o | output | 1 | MOSI pin output (master data out) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input (master data in) |
| miso_o | output | 1 | MISO pin output (slave data out) |
| miso_oe | output | 1 | MISO output enable |

## Verification
The hardest case to reach is a bus conflict that lands in the middle of a master word. At that moment the divider, the edge counter and the shifter are all partly advanced, and they must all fall back without a stray receive strobe. The bench starts a long full-width word with a slow divider, pulls the select input low a few edges in, and then watches the enables and the strobe. Master words run with MOSI looped back to MISO, so one transfer checks both directions. A monitor rebuilds the word from the pin at each capture edge the phase setting names. Slave words are driven bit by bit from the bench on a clock much slower than the system clock, so the synchronizer delay never blurs a capture edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef enum logic [1:0] {
      WLEN_BYTE  = 2'd0,
      WLEN_HALF  = 2'd1,
      WLEN_FULL  = 2'd2,
      WLEN_FULL2 = 2'd3
   } wlen_e;

   // number of bits carried by one word for a given length code
   function automatic int word_bits(input logic [1:0] code, input int full_w);
      case (wlen_e'(code))
         WLEN_BYTE: return 8;
         WLEN_HALF: return 16;
         default:   return full_w;
      endcase
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == div);

   // R2
   baud_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && run) |-> (cnt == '0));

   // R2
   baud_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
   parameter int DATA_W = 32,
   parameter int BITS_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic [BITS_W-1:0] nbits,
   input  logic              lsb_first,
   input  logic              edge_ev,
   input  logic              sample_en,
   input  logic              launch_en,
   input  logic              finish,
   input  logic              din,
   output logic              dout,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_valid
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] aligned;
   logic [DATA_W-1:0] mask;
   logic [BITS_W-1:0] shamt;
   logic              fin_q;

   assign shamt   = BITS_W'(DATA_W) - nbits;
   assign aligned = load_word << shamt;
   assign mask    = {DATA_W{1'b1}} >> shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         dout  <= 1'b0;
      end else if (load) begin
         if (lsb_first) begin
            dout  <= load_word[0];
            tx_sh <= load_word >> 1;
         end else begin
            dout  <= aligned[MSB];
            tx_sh <= aligned << 1;
         end
      end else if (edge_ev && launch_en) begin
         dout  <= lsb_first ? tx_sh[0] : tx_sh[MSB];
         tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh    <= '0;
         fin_q    <= 1'b0;
         rx_valid <= 1'b0;
         rx_word  <= '0;
      end else begin
         if (edge_ev && sample_en)
            rx_sh <= lsb_first ? {din, rx_sh[MSB:1]} : {rx_sh[MSB-1:0], din};
         fin_q    <= finish;
         rx_valid <= fin_q;
         if (fin_q)
            rx_word <= lsb_first ? (rx_sh >> shamt) : (rx_sh & mask);
      end
   end

   // R5
   rxv_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(finish, 2));

endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_miso_od,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              ovf_flag,
   output logic              mm_err,
   input  logic              status_clr,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe
);

   localparam int BITS_W = $clog2(DATA_W + 1);
   localparam int EDGE_W = $clog2(2 * DATA_W + 1);

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("spi_port DATA_W must be a multiple of 8 and at least 16");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_port DIV_W must be at least 1");
      end
   endgenerate

   logic              sclk_s, ss_s, mosi_s;
   logic              sclk_prev;
   logic              act_m;
   logic              run, phase, tick;
   logic [EDGE_W-1:0] edge_cnt;
   logic [EDGE_W-1:0] last_edge;
   logic [BITS_W-1:0] nbits;
   logic              slave_edge, edge_ev, at_last, finish;
   logic              sample_en, launch_en;
   logic              start, mm_set, din, dout;

   spi_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sclk_i, ss_n_i, mosi_i}),
      .q    ({sclk_s, ss_s, mosi_s})
   );

   spi_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (cfg_div),
      .tick (tick)
   );

   assign nbits      = BITS_W'(word_bits(cfg_len, DATA_W));
   assign last_edge  = EDGE_W'({nbits, 1'b0}) - 1'b1;
   assign act_m      = cfg_master && !mm_err;
   assign slave_edge = !act_m && !ss_s && (sclk_s != sclk_prev);
   assign edge_ev    = act_m ? (run && tick) : slave_edge;
   assign at_last    = (edge_cnt == last_edge);
   assign finish     = edge_ev && at_last;
   assign sample_en  = cfg_cpha ? edge_cnt[0] : !edge_cnt[0];
   assign launch_en  = cfg_cpha ? (!edge_cnt[0] && edge_cnt != '0)
                                : (edge_cnt[0] && !at_last);
   assign busy       = act_m ? run : (edge_cnt != '0);
   assign start      = tx_load && !busy;
   assign mm_set     = cfg_master && !ss_s && !mm_err;
   assign din        = act_m ? miso_i : mosi_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         mm_err    <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
         if (mm_set)          mm_err <= 1'b1;
         else if (status_clr) mm_err <= 1'b0;
         if (tx_load && busy) ovf_flag <= 1'b1;
         else if (status_clr) ovf_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         phase    <= 1'b0;
         edge_cnt <= '0;
      end else if (mm_set) begin
         run      <= 1'b0;
         phase    <= 1'b0;
         edge_cnt <= '0;
      end else if (act_m) begin
         if (!run) begin
            phase    <= 1'b0;
            edge_cnt <= '0;
            if (start) run <= 1'b1;
         end else if (tick) begin
            phase <= !phase;
            if (at_last) begin
               run      <= 1'b0;
               edge_cnt <= '0;
            end else begin
               edge_cnt <= edge_cnt + 1'b1;
            end
         end
      end else begin
         run   <= 1'b0;
         phase <= 1'b0;
         if (ss_s)            edge_cnt <= '0;
         else if (slave_edge) edge_cnt <= at_last ? '0 : edge_cnt + 1'b1;
      end
   end

   spi_shreg #(
      .DATA_W(DATA_W),
      .BITS_W(BITS_W)
   ) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_word(tx_data),
      .nbits    (nbits),
      .lsb_first(cfg_lsb_first),
      .edge_ev  (edge_ev),
      .sample_en(sample_en),
      .launch_en(launch_en),
      .finish   (finish),
      .din      (din),
      .dout     (dout),
      .rx_word  (rx_data),
      .rx_valid (rx_valid)
   );

   assign sclk_o  = cfg_cpol ^ phase;
   assign sclk_oe = act_m;
   assign mosi_o  = dout;
   assign mosi_oe = act_m;
   assign miso_o  = cfg_miso_od ? 1'b0 : dout;
   assign miso_oe = !act_m && !ss_n_i && (!cfg_miso_od || !dout);

   // R11
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && busy) |=> ovf_flag);

   // R10
   mm_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mm_err) |-> !run);

   // R1
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (edge_cnt <= last_edge));

   // R1
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> (sclk_o == cfg_cpol));

endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
   localparam int DATA_W = 32;
   localparam int DIV_W  = 8;

   // {len[76:75], lsb[74], cpol[73], cpha[72], div[71:64], data[63:32], expected[31:0]}
   localparam logic [76:0] VECS [6] = '{
      {2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 32'h0000_00A5, 32'h0000_00A5},
      {2'd0, 1'b1, 1'b1, 1'b1, 8'd0, 32'h1234_5637, 32'h0000_0037},
      {2'd1, 1'b0, 1'b0, 1'b1, 8'd2, 32'hDEAD_BEEF, 32'h0000_BEEF},
      {2'd1, 1'b1, 1'b1, 1'b0, 8'd3, 32'h0000_8001, 32'h0000_8001},
      {2'd2, 1'b0, 1'b1, 1'b1, 8'd0, 32'hC3A5_0F96, 32'hC3A5_0F96},
      {2'd3, 1'b1, 1'b0, 1'b0, 8'd1, 32'h8000_0001, 32'h8000_0001}
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_miso_od;
   logic [1:0]        cfg_len;
   logic [DIV_W-1:0]  cfg_div;
   logic [DATA_W-1:0] tx_data, rx_data;
   logic              tx_load, rx_valid, busy, ovf_flag, mm_err, status_clr;
   logic              sclk_i, sclk_o, sclk_oe, ss_n_i;
   logic              mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
   logic              loop_en, bench_miso;

   assign miso_i = loop_en ? mosi_o : bench_miso;

   spi_port #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_spi_port (
      .clk(clk), .rst_n(rst_n),
      .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_miso_od(cfg_miso_od),
      .cfg_div(cfg_div), .tx_data(tx_data), .tx_load(tx_load),
      .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
      .ovf_flag(ovf_flag), .mm_err(mm_err), .status_clr(status_clr),
      .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .ss_n_i(ss_n_i),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // monitor state
   bit          mon_en = 1'b0;
   logic        prev_sclk = 1'b0;
   int          ecount, sidx, gap, got_rx;
   bit          gap_bad, od_bad;
   logic [31:0] obs, rx_cap;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic mon_clear();
      ecount = 0; sidx = 0; gap = 0; got_rx = 0;
      gap_bad = 1'b0; od_bad = 1'b0; obs = '0; rx_cap = '0;
   endtask

   always @(negedge clk) begin
      if (mon_en && sclk_o !== prev_sclk) begin
         if (ecount > 0 && gap != int'(cfg_div)) gap_bad = 1'b1;
         gap = 0;
         if (cfg_cpha ? ecount[0] : !ecount[0]) begin
            if (cfg_lsb_first) obs[sidx] = mosi_o;
            else               obs = {obs[30:0], mosi_o};
            sidx++;
         end
         ecount++;
      end else begin
         gap++;
      end
      prev_sclk = sclk_o;
      if (rx_valid) begin
         got_rx++;
         rx_cap = rx_data;
      end
      if (miso_oe && cfg_miso_od && miso_o !== 1'b0) od_bad = 1'b1;
   end

   function automatic int nbits_of(input logic [1:0] code);
      return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
   endfunction

   task automatic run_master(input logic [76:0] v, input bit inj);
      int n;
      n = nbits_of(v[76:75]);
      cfg_master = 1'b1; loop_en = 1'b1; ss_n_i = 1'b1;
      cfg_len = v[76:75]; cfg_lsb_first = v[74]; cfg_cpol = v[73];
      cfg_cpha = v[72]; cfg_div = v[71:64];
      step(3);
      mon_clear();
      mon_en = 1'b1;
      tx_data = v[63:32]; tx_load = 1'b1;
      step(1);
      tx_load = 1'b0;
      if (inj) begin
         step(3);
         tx_data = 32'h0000_003C; tx_load = 1'b1;
         step(1);
         tx_load = 1'b0;
      end
      for (int t = 0; t < 8000 && got_rx == 0; t++) step(1);
      step(3);
      mon_en = 1'b0;
      // R1 edge count and idle level
      check(ecount == 2 * n, "R1 edge count", 32'(ecount), 32'(2 * n));
      check(sclk_o == v[73], "R1 idle level", {31'd0, sclk_o}, {31'd0, v[73]});
      // R2 half period
      check(!gap_bad, "R2 edge spacing", {31'd0, gap_bad}, 32'd0);
      // R3 R4 bits on MOSI at capture edges
      check(obs == v[31:0], "R3 R4 mosi word", obs, v[31:0]);
      // R5 loopback receive
      check(got_rx == 1 && rx_cap == v[31:0], "R5 rx word", rx_cap, v[31:0]);
   endtask

   task automatic run_slave(input logic [1:0] len, input bit lsb, input bit cpol,
                            input bit cpha, input bit od, input logic [31:0] txw,
                            input logic [31:0] rxw);
      int n;
      logic [31:0] mobs;
      logic m;
      n = nbits_of(len);
      mobs = '0;
      cfg_master = 1'b0; loop_en = 1'b0; ss_n_i = 1'b1;
      cfg_len = len; cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha;
      cfg_miso_od = od; sclk_i = cpol; mosi_i = 1'b0;
      step(4);
      mon_clear();
      tx_data = txw; tx_load = 1'b1;
      step(1);
      tx_load = 1'b0;
      ss_n_i = 1'b0;
      step(4);
      for (int k = 0; k < n; k++) begin
         logic b;
         b = lsb ? rxw[k] : rxw[n - 1 - k];
         if (!cpha) begin
            mosi_i = b; step(8);
            m = miso_oe ? miso_o : 1'b1;
            sclk_i = ~sclk_i; step(8);
            sclk_i = ~sclk_i;
         end else begin
            sclk_i = ~sclk_i; mosi_i = b; step(8);
            m = miso_oe ? miso_o : 1'b1;
            sclk_i = ~sclk_i; step(8);
         end
         if (lsb) mobs[k] = m;
         else     mobs = {mobs[30:0], m};
      end
      step(8);
      // R7 slave receive
      check(got_rx == 1 && rx_cap == rxw, "R7 slave rx word", rx_cap, rxw);
      // R8 slave transmit
      check(mobs == txw, "R8 slave miso word", mobs, txw);
      // R9 open drain never drives high
      check(!od_bad, "R9 open drain level", {31'd0, od_bad}, 32'd0);
      ss_n_i = 1'b1;
      #1;
      // R8 release on deselect
      check(miso_oe == 1'b0, "R8 miso release", {31'd0, miso_oe}, 32'd0);
      step(4);
   endtask

   initial begin
      rst_n = 1'b0; cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
      cfg_lsb_first = 1'b0; cfg_len = 2'd0; cfg_miso_od = 1'b0; cfg_div = '0;
      tx_data = '0; tx_load = 1'b0; status_clr = 1'b0; sclk_i = 1'b0;
      ss_n_i = 1'b1; mosi_i = 1'b0; loop_en = 1'b0; bench_miso = 1'b1;
      mon_clear();
      step(3);
      rst_n = 1'b1;
      step(2);

      // R12 reset state
      check({busy, rx_valid, ovf_flag, mm_err} == 4'b0, "R12 reset flags",
            {28'd0, busy, rx_valid, ovf_flag, mm_err}, 32'd0);
      check({sclk_oe, mosi_oe, miso_oe} == 3'b0, "R12 reset enables",
            {29'd0, sclk_oe, mosi_oe, miso_oe}, 32'd0);
      check(rx_data == '0, "R12 reset rx_data", rx_data, 32'd0);

      // R6 master pin directions
      cfg_master = 1'b1;
      step(1);
      check({sclk_oe, mosi_oe, miso_oe} == 3'b110, "R6 master enables",
            {29'd0, sclk_oe, mosi_oe, miso_oe}, 32'd6);

      // table of master words
      for (int i = 0; i < 6; i++) run_master(VECS[i], 1'b0);

      // R11 overflow during a word
      run_master(VECS[0], 1'b1);
      check(ovf_flag == 1'b1, "R11 overflow set", {31'd0, ovf_flag}, 32'd1);
      status_clr = 1'b1; step(1); status_clr = 1'b0; step(1);
      check(ovf_flag == 1'b0, "R11 overflow cleared", {31'd0, ovf_flag}, 32'd0);

      // R6 slave pin directions
      cfg_master = 1'b0;
      step(1);
      check({sclk_oe, mosi_oe} == 2'b00, "R6 slave enables",
            {30'd0, sclk_oe, mosi_oe}, 32'd0);

      // R7 clock ignored while deselected
      ss_n_i = 1'b1; cfg_len = 2'd0; cfg_cpha = 1'b0; cfg_cpol = 1'b0;
      step(4);
      mon_clear();
      for (int k = 0; k < 16; k++) begin
         sclk_i = ~sclk_i; mosi_i = k[1]; step(4);
      end
      check(got_rx == 0 && busy == 1'b0, "R7 deselected clock ignored",
            {31'd0, busy} | 32'(got_rx), 32'd0);
      check(miso_oe == 1'b0, "R8 deselected miso off", {31'd0, miso_oe}, 32'd0);

      // R7 partial word abandoned on deselect
      ss_n_i = 1'b0; step(4);
      for (int k = 0; k < 3; k++) begin
         sclk_i = ~sclk_i; step(6);
      end
      check(busy == 1'b1, "R7 partial word busy", {31'd0, busy}, 32'd1);
      ss_n_i = 1'b1; step(5);
      check(busy == 1'b0 && got_rx == 0, "R7 partial word dropped",
            {31'd0, busy} | 32'(got_rx), 32'd0);

      // slave words
      run_slave(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_005A, 32'h0000_00C3);
      run_slave(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_9C31, 32'h0000_1E87);

      // R10 conflict in the middle of a master word
      cfg_miso_od = 1'b0; cfg_master = 1'b1; loop_en = 1'b1; ss_n_i = 1'b1;
      cfg_len = 2'd2; cfg_lsb_first = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
      cfg_div = 8'd3; sclk_i = 1'b0;
      step(3);
      mon_clear();
      tx_data = 32'hFFFF_0000; tx_load = 1'b1; step(1); tx_load = 1'b0;
      step(20);
      check(busy == 1'b1, "R10 word running", {31'd0, busy}, 32'd1);
      ss_n_i = 1'b0;
      step(4);
      check(mm_err == 1'b1, "R10 conflict flag", {31'd0, mm_err}, 32'd1);
      check({sclk_oe, mosi_oe} == 2'b00, "R10 drivers released",
            {30'd0, sclk_oe, mosi_oe}, 32'd0);
      step(300);
      check(got_rx == 0 && busy == 1'b0, "R10 word aborted",
            {31'd0, busy} | 32'(got_rx), 32'd0);
      ss_n_i = 1'b1; step(4);
      status_clr = 1'b1; step(1); status_clr = 1'b0; step(1);
      check(mm_err == 1'b0 && sclk_oe == 1'b1, "R10 clear restores master",
            {30'd0, mm_err, sclk_oe}, 32'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

endmodule